// File: doc/BRIEF.md
# Interleaved Two-Converter Sample Collector

This block runs two identical sampling converters in time-interleaved fashion and merges their results into one stream at twice the rate of either converter. A counter divides the system clock into a slow sample clock. Converter A gets a start pulse on the rising transition of that clock, and converter B gets one on the falling transition. The two converters therefore sample half a sample period apart. With each converter at about 1 MHz, the merged stream carries about two million samples per second.

Each converter returns a parallel result together with an end-of-conversion strobe. A steering select accepts results in strict A, B, A, B order and feeds a single four-slot packing buffer. Each stored sample carries a one-bit source tag, so that downstream logic can apply per-converter gain and offset correction. This block performs no such correction, so the merged stream may not reach the full resolution of either converter. When all four slots hold data, the block raises a transfer request. The request stays high until an acknowledge empties the buffer.

Top module: `ileave_collector`

## Requirements
- R1: After a synchronous active-high reset, both trigger outputs, the transfer request, the ordering-error flag and the overflow flag are low, the buffer is empty and converter A is expected first.
- R2: Counting system clock edges after reset release, `trig_a_o` is a one-cycle pulse seen after edge DIV_HALF and then every 2*DIV_HALF edges.
- R3: `trig_b_o` is a one-cycle pulse seen exactly DIV_HALF edges after each `trig_a_o` pulse, and the two triggers are never high together.
- R4: Strobes from the expected converter are accepted alternately, starting with A. The k-th accepted sample since the buffer was last empty is stored in slot k, at bits [k*DATA_W +: DATA_W] of `buf_data_o`, with tag bit k of `buf_tag_o` set to 0 for A and 1 for B.
- R5: `xfer_req_o` is high exactly when all four slots are filled, and it stays high until acknowledged.
- R6: When `xfer_ack_i` is high while the request is high, the buffer empties and the request is low after that edge. An acknowledge while the request is low has no effect.
- R7: A strobe from the converter that is not expected stores nothing, leaves the select unchanged and sets the sticky `order_err_o` flag.
- R8: An expected strobe that arrives while the buffer is full is dropped and leaves the stored contents unchanged. It sets the sticky `overflow_o` flag and still advances the select to the other converter.
- R9: If an acknowledge and an expected strobe arrive in the same cycle while the buffer is full, the buffer empties and the new sample becomes slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_a_o | output | 1 | Start-of-conversion pulse to converter A |
| trig_b_o | output | 1 | Start-of-conversion pulse to converter B |
| a_eoc_i | input | 1 | End-of-conversion strobe from converter A |
| a_data_i | input | DATA_W | Result bus of converter A |
| b_eoc_i | input | 1 | End-of-conversion strobe from converter B |
| b_data_i | input | DATA_W | Result bus of converter B |
| xfer_req_o | output | 1 | Buffer full, block transfer requested |
| xfer_ack_i | input | 1 | Transfer done, empty the buffer |
| buf_data_o | output | BUF_DEPTH*DATA_W | Buffer slots, slot 0 in the low bits |
| buf_tag_o | output | BUF_DEPTH | Source tag per slot (0 = A, 1 = B) |
| order_err_o | output | 1 | Sticky out-of-order strobe flag |
| overflow_o | output | 1 | Sticky dropped-sample flag |

## Verification
The bench builds the block with DATA_W = 12 and DIV_HALF = 4. The 12-bit width uses the widest result bus and places data in the upper slot bits, where a narrow-width slip would show. The short half period yields several trigger pairs in a few dozen cycles, so the A-to-B spacing and the repeat period can be checked edge by edge. The default buffer depth of four lets the fill, overflow and simultaneous acknowledge-and-push cases be reached with only a handful of strobes.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;
endpackage

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen #(
    parameter int DIV_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    output logic trig_a_o,
    output logic trig_b_o
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
        logic          trig_a;
        logic          trig_b;
    } st_t;

    st_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d          = st_q;
        wrap          = (st_q.cnt == LAST);
        st_d.cnt      = wrap ? '0 : st_q.cnt + 1'b1;
        st_d.phase    = st_q.phase ^ wrap;
        // rising transition of the divided clock starts A, falling starts B
        st_d.trig_a   = wrap & ~st_q.phase;
        st_d.trig_b   = wrap &  st_q.phase;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign trig_a_o = st_q.trig_a;
    assign trig_b_o = st_q.trig_b;
endmodule

// File: rtl/ilv_steer.sv
module ilv_steer
    import ilv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_eoc_i,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              b_eoc_i,
    input  logic [DATA_W-1:0] b_data_i,
    output logic              push_o,
    output logic [DATA_W-1:0] push_data_o,
    output src_e              push_src_o,
    output logic              order_err_o
);
    typedef struct packed {
        src_e sel;
        logic err;
    } st_t;

    st_t  st_d, st_q;
    logic exp_eoc, stray_eoc;

    always_comb begin
        st_d        = st_q;
        exp_eoc     = (st_q.sel == SRC_B) ? b_eoc_i : a_eoc_i;
        stray_eoc   = (st_q.sel == SRC_B) ? a_eoc_i : b_eoc_i;
        push_o      = exp_eoc;
        push_data_o = (st_q.sel == SRC_B) ? b_data_i : a_data_i;
        push_src_o  = st_q.sel;
        if (exp_eoc) st_d.sel = (st_q.sel == SRC_A) ? SRC_B : SRC_A;
        st_d.err    = st_q.err | stray_eoc;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{sel: SRC_A, err: 1'b0};
        else     st_q <= st_d;
    end

    assign order_err_o = st_q.err;
endmodule

// File: rtl/ilv_pack_buf.sv
module ilv_pack_buf
    import ilv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push_i,
    input  logic [DATA_W-1:0]       push_data_i,
    input  src_e                    push_src_i,
    input  logic                    ack_i,
    output logic                    req_o,
    output logic [DEPTH*DATA_W-1:0] data_o,
    output logic [DEPTH-1:0]        tag_o,
    output logic                    ovf_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0]                cnt;
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic [DEPTH-1:0]             tag;
        logic                         ovf;
    } st_t;

    st_t           st_d, st_q;
    logic          full;
    logic [CW-1:0] base;

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == FULL_CNT);
        base = (full && ack_i) ? '0 : st_q.cnt;
        st_d.cnt = base;
        if (push_i) begin
            if (base == FULL_CNT) begin
                st_d.ovf = 1'b1;
            end else begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (base == CW'(k)) begin
                        st_d.slot[k] = push_data_i;
                        st_d.tag[k]  = (push_src_i == SRC_B);
                    end
                end
                st_d.cnt = base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_o  = (st_q.cnt == FULL_CNT);
    assign data_o = st_q.slot;
    assign tag_o  = st_q.tag;
    assign ovf_o  = st_q.ovf;
endmodule

// File: rtl/ileave_collector.sv
module ileave_collector
    import ilv_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_HALF  = 50,
    parameter int BUF_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic                        trig_a_o,
    output logic                        trig_b_o,
    input  logic                        a_eoc_i,
    input  logic [DATA_W-1:0]           a_data_i,
    input  logic                        b_eoc_i,
    input  logic [DATA_W-1:0]           b_data_i,
    output logic                        xfer_req_o,
    input  logic                        xfer_ack_i,
    output logic [BUF_DEPTH*DATA_W-1:0] buf_data_o,
    output logic [BUF_DEPTH-1:0]        buf_tag_o,
    output logic                        order_err_o,
    output logic                        overflow_o
);
    logic              push;
    logic [DATA_W-1:0] push_data;
    src_e              push_src;

    ilv_phase_gen #(.DIV_HALF(DIV_HALF)) phase_i (
        .clk      (clk),
        .rst      (rst),
        .trig_a_o (trig_a_o),
        .trig_b_o (trig_b_o)
    );

    ilv_steer #(.DATA_W(DATA_W)) steer_i (
        .clk         (clk),
        .rst         (rst),
        .a_eoc_i     (a_eoc_i),
        .a_data_i    (a_data_i),
        .b_eoc_i     (b_eoc_i),
        .b_data_i    (b_data_i),
        .push_o      (push),
        .push_data_o (push_data),
        .push_src_o  (push_src),
        .order_err_o (order_err_o)
    );

    ilv_pack_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) buf_i (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .push_data_i (push_data),
        .push_src_i  (push_src),
        .ack_i       (xfer_ack_i),
        .req_o       (xfer_req_o),
        .data_o      (buf_data_o),
        .tag_o       (buf_tag_o),
        .ovf_o       (overflow_o)
    );
endmodule

// File: rtl/ilv_collector_chk.sv
module ilv_collector_chk #(
    parameter int DIV_HALF = 50
) (
    input logic clk,
    input logic rst,
    input logic trig_a,
    input logic trig_b,
    input logic req,
    input logic ack,
    input logic order_err,
    input logic overflow
);
    logic [31:0] since_a_q;

    always_ff @(posedge clk) begin
        if (rst)         since_a_q <= '0;
        else if (trig_a) since_a_q <= 32'd1;
        else if (since_a_q != 32'hFFFF_FFFF) since_a_q <= since_a_q + 1'b1;
    end

    assert_trig_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(trig_a && trig_b));
    assert_trig_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        trig_b |-> (since_a_q == 32'(DIV_HALF)));
    assert_trig_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        trig_a |=> !trig_a);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);
    assert_ack_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);
    assert_order_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        order_err |=> order_err);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind ileave_collector ilv_collector_chk #(.DIV_HALF(DIV_HALF)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .trig_a    (trig_a_o),
    .trig_b    (trig_b_o),
    .req       (xfer_req_o),
    .ack       (xfer_ack_i),
    .order_err (order_err_o),
    .overflow  (overflow_o)
);

// File: tb/ileave_collector_tb.sv
module ileave_collector_tb_top;
    localparam int DW   = 12;
    localparam int HALF = 4;
    localparam int NB   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_a, trig_b;
    logic          a_eoc = 1'b0, b_eoc = 1'b0, ack = 1'b0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic          req, oerr, ovf;
    logic [NB*DW-1:0] bdata;
    logic [NB-1:0]    btag;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // bit 12: source (0 = A, 1 = B), bits 11:0: sample value
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 12'h123}, {1'b1, 12'hABC}, {1'b0, 12'h800}, {1'b1, 12'h7FF},
        {1'b0, 12'h001}, {1'b1, 12'hFFE}, {1'b0, 12'h5A5}, {1'b1, 12'h0F0}
    };

    always #4 clk = ~clk;

    ileave_collector #(.DATA_W(DW), .DIV_HALF(HALF), .BUF_DEPTH(NB)) dut_i (
        .clk (clk), .rst (rst),
        .trig_a_o (trig_a), .trig_b_o (trig_b),
        .a_eoc_i (a_eoc), .a_data_i (a_data),
        .b_eoc_i (b_eoc), .b_data_i (b_data),
        .xfer_req_o (req), .xfer_ack_i (ack),
        .buf_data_o (bdata), .buf_tag_o (btag),
        .order_err_o (oerr), .overflow_o (ovf)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int slot(input int k);
        return int'(bdata[k*DW +: DW]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; a_eoc = 0; b_eoc = 0; ack = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input bit src, input logic [DW-1:0] v);
        if (src) begin b_eoc = 1'b1; b_data = v; end
        else     begin a_eoc = 1'b1; a_data = v; end
        @(negedge clk);
        a_eoc = 1'b0; b_eoc = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad_a, bad_b;
        do_reset();
        // R1 reset state, sampled right after release
        chk(!trig_a && !trig_b, "R1 triggers", {trig_a, trig_b}, 0);
        chk(!req && !oerr && !ovf, "R1 flags", {req, oerr, ovf}, 0);

        // R2/R3 trigger schedule: n counts edges after reset release
        bad_a = 0; bad_b = 0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (trig_a !== ((n % (2*HALF)) == HALF)) bad_a++;
            if (trig_b !== ((n % (2*HALF)) == 0))    bad_b++;
        end
        chk(bad_a == 0, "R2 trig_a schedule", bad_a, 0);
        chk(bad_b == 0, "R3 trig_b schedule", bad_b, 0);

        // R4/R5/R6 vector walk in A,B order
        do_reset();
        for (int i = 0; i < 8; i++) begin
            strobe(VEC[i][12], VEC[i][DW-1:0]);
            if ((i % 4) != 3) begin
                chk(req == 1'b0, "R5 req low while filling", req, 0);
            end else begin
                chk(req == 1'b1, "R5 req on full", req, 1);
                for (int k = 0; k < 4; k++) begin
                    chk(slot(k) == int'(VEC[i-3+k][DW-1:0]), "R4 slot data",
                        slot(k), int'(VEC[i-3+k][DW-1:0]));
                    chk(btag[k] == VEC[i-3+k][12], "R4 slot tag",
                        btag[k], VEC[i-3+k][12]);
                end
                @(negedge clk);
                chk(req == 1'b1, "R5 req holds without ack", req, 1);
                pulse_ack();
                chk(req == 1'b0, "R6 req drops after ack", req, 0);
            end
        end
        chk(!oerr && !ovf, "R7 R8 no flags on clean run", {oerr, ovf}, 0);

        // R7 stray B first
        do_reset();
        strobe(1'b1, 12'hBAD);
        chk(oerr == 1'b1, "R7 order_err set", oerr, 1);
        strobe(1'b0, 12'h111); strobe(1'b1, 12'h222);
        strobe(1'b0, 12'h333);
        chk(req == 1'b0, "R7 stray sample not stored", req, 0);
        strobe(1'b1, 12'h444);
        chk(req == 1'b1 && slot(0) == 12'h111, "R7 slot0 from A", slot(0), 12'h111);
        chk(btag[0] == 1'b0, "R7 slot0 tag A", btag[0], 0);
        chk(oerr == 1'b1, "R7 order_err sticky", oerr, 1);

        // R8 overflow while full
        do_reset();
        strobe(1'b0, 12'h010); strobe(1'b1, 12'h020);
        strobe(1'b0, 12'h030); strobe(1'b1, 12'h040);
        strobe(1'b0, 12'hFFF);
        chk(ovf == 1'b1, "R8 overflow set", ovf, 1);
        chk(slot(0) == 12'h010 && slot(3) == 12'h040, "R8 contents kept", slot(0), 12'h010);
        pulse_ack();
        strobe(1'b1, 12'h0B0);
        chk(oerr == 1'b0, "R8 select advanced past dropped A", oerr, 0);
        chk(slot(0) == 12'h0B0 && btag[0] == 1'b1, "R8 next sample is B", slot(0), 12'h0B0);
        chk(ovf == 1'b1, "R8 overflow sticky", ovf, 1);

        // R6 ack while not full is ignored (one entry held)
        pulse_ack();
        strobe(1'b0, 12'h0A1); strobe(1'b1, 12'h0B1);
        chk(req == 1'b0, "R6 ignored ack kept count", req, 0);
        strobe(1'b0, 12'h0A2);
        chk(req == 1'b1, "R6 full after four", req, 1);
        chk(slot(0) == 12'h0B0, "R6 slot0 kept", slot(0), 12'h0B0);

        // R9 ack and push together while full; next expected is B
        ack = 1'b1;
        strobe(1'b1, 12'hC0D);
        ack = 1'b0;
        chk(req == 1'b0, "R9 drained", req, 0);
        chk(slot(0) == 12'hC0D && btag[0] == 1'b1, "R9 new slot0", slot(0), 12'hC0D);
        strobe(1'b0, 12'h00E);
        chk(slot(1) == 12'h00E && btag[1] == 1'b0, "R9 follows in slot1", slot(1), 12'h00E);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule